// File: doc/BRIEF.md
# Serial-Loaded Four-Latch Register Bank

This block receives the control words of a frequency synthesizer through a three-wire serial port: a serial clock, a data line and a load strobe. Each 24-bit word is shifted in with its most significant bit first. When the load strobe rises, the word is written into one of four holding latches: reference divider, feedback counter, function or initialization. The two least significant bits of the word pick the latch.

The serial pins are slow and asynchronous to the fast system clock that runs the block. All three pins pass through a synchronizer before they are used. Edges of the serial clock and of the load pin are found in the system clock domain. The decoded fields go to the rest of the design as registered outputs:
- the 14-bit reference ratio and a flag that marks it valid,
- the 6-bit A count and the 13-bit B count,
- the 22-bit payloads of the function and initialization words,
- one load strobe per latch.

A zero reference ratio is illegal. A word that carries one is refused and raises an error flag.

Top module: `serial_latch_bank`

## Requirements
- R1: The shift register is 24 bits wide. It takes one bit from the data pin on each rising edge of the serial clock pin. The first bit shifted in ends up as bit 23 of the word.
- R2: A rising edge on the load pin moves the shifted word into exactly one latch, chosen by word bits [1:0]: 0 is reference, 1 is feedback counter, 2 is function and 3 is initialization.
- R3: A reference load that is accepted sets the reference ratio output to word bits [15:2] and raises the reference valid flag.
- R4: A feedback counter load sets the A count to word bits [7:2] and the B count to word bits [20:8].
- R5: A reference load whose bits [15:2] are zero is refused:
  - the reference ratio, the valid flag and all strobes stay unchanged;
  - the error flag is set;
  - the error flag stays set until the next accepted reference load, which clears it.
- R6: Function and initialization loads each store word bits [23:2] as a 22-bit payload with the same layout.
- R7: Each update of a latch pulses load strobe bit n for exactly one system clock cycle, where n is the select code of R2. The pulse comes in the same cycle that the new field values appear.
- R8: After reset, all of these are zero: the ratio, the A and B counts, both payloads, the valid flag, the error flag and the strobes.
- R9: Shifting bits without a rising edge on the load pin changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock pin, asynchronous |
| ser_dat | input | 1 | Serial data pin, asynchronous |
| ser_load | input | 1 | Load pin; a rising edge commits the word |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_valid | output | 1 | Set once a nonzero ratio has been loaded |
| ref_zero_err | output | 1 | Set by a refused zero-ratio load |
| a_count | output | 6 | A counter value |
| b_count | output | 13 | B counter value |
| func_word | output | 22 | Function latch payload |
| init_word | output | 22 | Initialization latch payload |
| load_strobe | output | 4 | One-cycle update pulse per latch |

## Verification
Known synthesizer programming words are sent to every latch, and the fields that come out must match. Because these words are asymmetric, a reversed shift order or a shifted field boundary shows up at once. A word with all bits set is shifted in with the load pin held low and then committed on its own. This separates shifting from committing and proves that the initialization payload keeps every bit. A zero-ratio word with nonzero upper bits shows that the zero test looks only at the ratio field. It is followed by the largest legal ratio and the largest A and B counts, which test the error clear and the top bit of each field.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W  = 24;
  localparam int SEL_W   = 2;
  localparam int NLATCH  = 4;
  localparam int PAY_W   = WORD_W - SEL_W;
  localparam int REF_LSB = 2;
  localparam int REF_W   = 14;
  localparam int A_LSB   = 2;
  localparam int A_W     = 6;
  localparam int B_LSB   = 8;
  localparam int B_W     = 13;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF  = 2'd0,
    SEL_NCNT = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_INIT = 2'd3
  } latch_sel_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pin;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/edge_rise.sv
module edge_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/shift_capture.sv
module shift_capture #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/latch_bank.sv
module latch_bank
  import slb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic [WORD_W-1:0]   word,
  output logic [REF_W-1:0]    ref_ratio,
  output logic                ref_valid,
  output logic                ref_zero_err,
  output logic [A_W-1:0]      a_count,
  output logic [B_W-1:0]      b_count,
  output logic [PAY_W-1:0]    func_word,
  output logic [PAY_W-1:0]    init_word,
  output logic [NLATCH-1:0]   load_strobe
);
  latch_sel_e         sel;
  logic [REF_W-1:0]   ref_field;
  logic [A_W-1:0]     a_field;
  logic [B_W-1:0]     b_field;
  logic [PAY_W-1:0]   payload;

  assign sel       = latch_sel_e'(word[SEL_W-1:0]);
  assign ref_field = word[REF_LSB +: REF_W];
  assign a_field   = word[A_LSB +: A_W];
  assign b_field   = word[B_LSB +: B_W];
  assign payload   = word[WORD_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ratio    <= '0;
      ref_valid    <= 1'b0;
      ref_zero_err <= 1'b0;
      a_count      <= '0;
      b_count      <= '0;
      func_word    <= '0;
      init_word    <= '0;
      load_strobe  <= '0;
    end else begin
      load_strobe <= '0;
      if (commit) begin
        unique case (sel)
          SEL_REF: begin
            if (ref_field == '0) begin
              ref_zero_err <= 1'b1;
            end else begin
              ref_ratio      <= ref_field;
              ref_valid      <= 1'b1;
              ref_zero_err   <= 1'b0;
              load_strobe[0] <= 1'b1;
            end
          end
          SEL_NCNT: begin
            a_count        <= a_field;
            b_count        <= b_field;
            load_strobe[1] <= 1'b1;
          end
          SEL_FUNC: begin
            func_word      <= payload;
            load_strobe[2] <= 1'b1;
          end
          SEL_INIT: begin
            init_word      <= payload;
            load_strobe[3] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import slb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_dat,
  input  logic                ser_load,
  output logic [REF_W-1:0]    ref_ratio,
  output logic                ref_valid,
  output logic                ref_zero_err,
  output logic [A_W-1:0]      a_count,
  output logic [B_W-1:0]      b_count,
  output logic [PAY_W-1:0]    func_word,
  output logic [PAY_W-1:0]    init_word,
  output logic [NLATCH-1:0]   load_strobe
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   pins_lvl;
  logic [1:0]        edge_hit;
  logic [WORD_W-1:0] shift_word;

  bit_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   ({ser_load, ser_clk, ser_dat}),
    .level (pins_lvl)
  );

  edge_rise #(.W(2)) u_edges (
    .clk   (clk),
    .rst   (rst),
    .level (pins_lvl[2:1]),
    .rise  (edge_hit)
  );

  shift_capture #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (edge_hit[0]),
    .din      (pins_lvl[0]),
    .word     (shift_word)
  );

  latch_bank u_bank (
    .clk          (clk),
    .rst          (rst),
    .commit       (edge_hit[1]),
    .word         (shift_word),
    .ref_ratio    (ref_ratio),
    .ref_valid    (ref_valid),
    .ref_zero_err (ref_zero_err),
    .a_count      (a_count),
    .b_count      (b_count),
    .func_word    (func_word),
    .init_word    (init_word),
    .load_strobe  (load_strobe)
  );
endmodule

// File: rtl/slb_checker.sv
module slb_checker
  import slb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [REF_W-1:0]  ref_ratio,
  input logic              ref_valid,
  input logic              ref_zero_err,
  input logic [A_W-1:0]    a_count,
  input logic [B_W-1:0]    b_count,
  input logic [PAY_W-1:0]  func_word,
  input logic [PAY_W-1:0]  init_word,
  input logic [NLATCH-1:0] load_strobe
);
  assert_one_latch_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_strobe));

  assert_pulse_short_R7: assert property (@(posedge clk) disable iff (rst)
    (load_strobe != '0) |=> (load_strobe == '0));

  assert_valid_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    ref_valid |-> (ref_ratio != '0));

  assert_err_no_load_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_zero_err) |-> (!load_strobe[0] && $stable(ref_ratio)));

  assert_ref_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load_strobe[0] |-> ($stable(ref_ratio) && !$rose(ref_valid)));

  assert_ncnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load_strobe[1] |-> ($stable(a_count) && $stable(b_count)));

  assert_pay_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load_strobe[2] |-> $stable(func_word)) and
    (!load_strobe[3] |-> $stable(init_word)));
endmodule

bind serial_latch_bank slb_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .ref_ratio    (ref_ratio),
  .ref_valid    (ref_valid),
  .ref_zero_err (ref_zero_err),
  .a_count      (a_count),
  .b_count      (b_count),
  .func_word    (func_word),
  .init_word    (init_word),
  .load_strobe  (load_strobe)
);

// File: tb/serial_latch_bank_test.sv
module serial_latch_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_ratio;
  logic        ref_valid, ref_zero_err;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic [21:0] func_word, init_word;
  logic [3:0]  load_strobe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  serial_latch_bank uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .ref_ratio(ref_ratio), .ref_valid(ref_valid),
    .ref_zero_err(ref_zero_err), .a_count(a_count), .b_count(b_count),
    .func_word(func_word), .init_word(init_word), .load_strobe(load_strobe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_dat = w[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(2);
    end
  endtask

  task automatic pulse_load();
    wait_clk(2);
    ser_load = 1'b1;
    wait_clk(4);
    ser_load = 1'b0;
    wait_clk(6);
  endtask

  // driver: pushes expected word, then sends it
  task automatic send(input logic [23:0] w, input bit expect_load);
    if (expect_load) exp_q.push_back(w);
    shift_bits(w);
    pulse_load();
  endtask

  // monitor: pops an expected word on every strobe and compares
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && load_strobe != 4'd0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "strobe with no expected load", 32'(load_strobe), 0);
        end else begin
          logic [23:0] w;
          w = exp_q.pop_front();
          check(load_strobe == (4'd1 << w[1:0]), "R7", "strobe bit",
                32'(load_strobe), 32'(4'd1 << w[1:0]));
          case (w[1:0])
            2'd0: begin
              check(ref_ratio == w[15:2], "R3", "ref ratio", 32'(ref_ratio), 32'(w[15:2]));
              check(ref_valid && !ref_zero_err, "R3", "valid/err", {ref_valid, ref_zero_err}, 32'b10);
            end
            2'd1: begin
              check(a_count == w[7:2], "R4", "A count", 32'(a_count), 32'(w[7:2]));
              check(b_count == w[20:8], "R4", "B count", 32'(b_count), 32'(w[20:8]));
            end
            2'd2: check(func_word == w[23:2], "R6", "func payload", 32'(func_word), 32'(w[23:2]));
            default: check(init_word == w[23:2], "R6", "init payload", 32'(init_word), 32'(w[23:2]));
          endcase
          @(negedge clk);
          check(load_strobe == 4'd0, "R7", "strobe one cycle", 32'(load_strobe), 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    wait_clk(200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    wait_clk(5);
    @(negedge clk);
    // R8 reset state
    check(ref_ratio == 0 && a_count == 0 && b_count == 0, "R8", "counters after reset",
          {ref_ratio, a_count, b_count}, 0);
    check(func_word == 0 && init_word == 0, "R8", "payloads after reset",
          32'(func_word | init_word), 0);
    check(!ref_valid && !ref_zero_err && load_strobe == 0, "R8", "flags after reset",
          {ref_valid, ref_zero_err, load_strobe}, 0);
    rst = 1'b0;
    wait_clk(4);

    // R1 R2 typical programming sequence, MSB first
    send(24'h8000C3, 1'b1);
    send(24'h000028, 1'b1);
    send(24'h004C49, 1'b1);
    send(24'h8000C2, 1'b1);
    send(24'h004D31, 1'b1);
    send(24'h9B50A2, 1'b1);
    send(24'h110028, 1'b1);
    @(negedge clk);
    check(a_count == 6'd12 && b_count == 13'd77, "R4", "held A/B from 0x004D31",
          {a_count, b_count}, {6'd12, 13'd77});
    check(ref_ratio == 14'd10, "R1", "ref ratio 10 MSB-first", 32'(ref_ratio), 10);

    // R9 shifting without load changes nothing
    shift_bits(24'hFFFFFF);
    wait_clk(6);
    @(negedge clk);
    check(ref_ratio == 14'd10 && a_count == 6'd12 && b_count == 13'd77, "R9",
          "outputs after shift only", {ref_ratio, a_count, b_count}, {14'd10, 6'd12, 13'd77});
    check(init_word == 22'h200030 && func_word == (24'h9B50A2 >> 2), "R9",
          "payloads after shift only", 32'(init_word), 32'h200030);
    exp_q.push_back(24'hFFFFFF);
    pulse_load();

    // R5 zero ratio refused (upper bits nonzero)
    send(24'hFF0000, 1'b0);
    @(negedge clk);
    check(ref_zero_err, "R5", "error flag set", 32'(ref_zero_err), 1);
    check(ref_ratio == 14'd10 && ref_valid, "R5", "ratio kept",
          {ref_valid, ref_ratio}, {1'b1, 14'd10});

    // R5 error cleared by legal load, max ratio
    send(24'h00FFFC, 1'b1);
    @(negedge clk);
    check(!ref_zero_err && ref_ratio == 14'h3FFF, "R5", "cleared on legal load",
          {ref_zero_err, ref_ratio}, {1'b0, 14'h3FFF});

    // R4 maximum counts
    send(24'h1FFFFD, 1'b1);
    wait_clk(4);
    check(exp_q.size() == 0, "R2", "all expected loads seen", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule